// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block routes a set of external interrupt lines to interrupt messages. Software reaches it through just two bus registers. A select register holds the index of an internal register. A 32-bit window register then reads or writes whichever internal register the select register points at. The internal registers are:

- a unit identification register;
- a version register, which reports how large the table is;
- a table of redirection entries, one per input line, each split into a low word and a high word.

Each entry gives its line a vector, a destination, a trigger mode and a mask. When an unmasked line signals an interrupt, the block presents a message carrying that entry's vector and destination on a valid/ready output. Edge entries fire once per rising edge. Level entries fire once, then wait until an end-of-interrupt naming their vector releases them. When several lines want service at the same time, the lowest-numbered line goes first.

Top module: `irq_redirect_table`

## Requirements
- R1: After reset, the select register reads 0 and `msgValid` is low. Every entry's low word reads 0x0001_0000 (only the mask bit set) and every high word reads 0.
- R2: Bus offset 0x00 is the 8-bit select register, readable and writable in bits 7:0. Bus offset 0x10 reads or writes the internal register the select register names. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R3: Internal index 0x00 is the identification register. Bits 31:24 are writable and read back; all other bits read 0.
- R4: Internal index 0x01 is the version register. Bits 23:16 read the highest entry index (23 by default), bits 7:0 read 0x11, all other bits read 0, and writes to it are ignored.
- R5: Entry n sits at index 0x10+2n (low word) and 0x11+2n (high word).
  - Low word fields: bits 7:0 are the vector, bit 15 is the trigger mode (1 = level), bit 16 is the mask, and bit 14 is a read-only remote-pending flag.
  - High word fields: bits 31:24 are the destination.
  - All other bits read 0, and indices past the last entry read 0.
- R6: A masked entry never issues a message. A rising edge that arrives while the entry is masked is not remembered when the entry is later unmasked.
- R7: An unmasked edge entry (bit 15 = 0) issues exactly one message per rising edge of its input, carrying its vector and destination. An input held high does not repeat the message.
- R8: An unmasked level entry issues a message while its input is high and its remote-pending flag is clear, and issuing sets the flag. No further message comes until an end-of-interrupt with a matching vector clears the flag.
- R9: An end-of-interrupt whose vector differs from the entry's vector leaves the remote-pending flag set and causes no message.
- R10: Arbitration and output handshake:
  - Among lines requesting at the same time, the lowest-numbered entry is sent first.
  - A message stays on `msgVector`/`msgDest` with `msgValid` high until `msgReady` is seen.
  - `msgValid` is low in the cycle after acceptance.
- R11: If an end-of-interrupt clears one level entry's flag in the same cycle that another level entry with the same vector is granted, the granted entry's flag ends up set. The released entry is delivered again if its input is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Bus byte offset |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe; read data is valid in the same cycle |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, 0 when no read is requested |
| irqIn | input | 24 | Interrupt input lines, one per entry |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Message accepted by the receiver |
| msgVector | output | 8 | Vector of the message being presented |
| msgDest | output | 8 | Destination of the message being presented |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector named by the end-of-interrupt |

## Verification
Two things can land in the same clock edge: an end-of-interrupt that clears one level entry's remote-pending flag, and the grant of a second level entry that sets its own flag. The bench makes them coincide using two level lines that share a vector. It accepts the first line's message and, in the very next cycle, drives the end-of-interrupt, which is exactly the cycle in which the second line is granted. It then judges the outcome at the ports in three ways: the second message carries the second line's destination; the second entry's low word still shows bit 14 set; and the first line is delivered once more because its input is still high.

// File: rtl/irt_pkg.sv
package irt_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic       wrId;    // write to the identification register
    logic       wrLow;   // write to the low word of entry 'entry'
    logic       wrHigh;  // write to the high word of entry 'entry'
    logic       fire;    // latch the arbitration winner into the output
    logic [7:0] entry;   // entry addressed by the current select value
  } irt_strobe_t;

  localparam logic [7:0] VERSION_CODE = 8'h11;

endpackage

// File: rtl/irt_datapath.sv
module irt_datapath
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  irt_strobe_t          st,
  input  logic [31:0]          wdata,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector,
  output logic                 reqAny,
  output logic [7:0]           idRd,
  output logic [31:0]          loRd,
  output logic [31:0]          hiRd,
  output logic [7:0]           msgVector,
  output logic [7:0]           msgDest
);

  logic [7:0]           vecQ  [NUM_LINES];
  logic [7:0]           destQ [NUM_LINES];
  logic [NUM_LINES-1:0] levelQ, maskQ, remoteQ, pendQ, prevQ;
  logic [NUM_LINES-1:0] reqVec;
  logic [IDX_W-1:0]     grantIdx, entIdx;
  logic                 entryOk;
  logic [7:0]           idQ, msgVecQ, msgDestQ;

  assign entIdx  = st.entry[IDX_W-1:0];
  assign entryOk = int'(st.entry) < NUM_LINES;

  // Per-line request: an edge entry that has a pending edge, or a level
  // entry whose input is high and which is not waiting for an EOI.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_req
    assign reqVec[g] = !maskQ[g] &&
                       (levelQ[g] ? (irqIn[g] && !remoteQ[g]) : pendQ[g]);
  end

  // Fixed priority: the lowest-numbered requester wins.
  always_comb begin
    grantIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqVec[i]) grantIdx = IDX_W'(i);
    end
  end
  assign reqAny = |reqVec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idQ      <= '0;
      msgVecQ  <= '0;
      msgDestQ <= '0;
      levelQ   <= '0;
      maskQ    <= '1;
      remoteQ  <= '0;
      pendQ    <= '0;
      prevQ    <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vecQ[i]  <= '0;
        destQ[i] <= '0;
      end
    end else begin
      prevQ <= irqIn;
      if (st.wrId) idQ <= wdata[31:24];
      if (st.fire) begin
        msgVecQ  <= vecQ[grantIdx];
        msgDestQ <= destQ[grantIdx];
      end
      for (int i = 0; i < NUM_LINES; i++) begin
        logic hitW, won;
        hitW = entryOk && (entIdx == IDX_W'(i));
        won  = st.fire && (grantIdx == IDX_W'(i));
        if (st.wrLow && hitW) begin
          vecQ[i]   <= wdata[7:0];
          levelQ[i] <= wdata[15];
          maskQ[i]  <= wdata[16];
        end
        if (st.wrHigh && hitW) destQ[i] <= wdata[31:24];
        // Remote-pending: a grant sets it, and the set wins over an EOI.
        if (won && levelQ[i])
          remoteQ[i] <= 1'b1;
        else if (eoiValid && levelQ[i] && (vecQ[i] == eoiVector))
          remoteQ[i] <= 1'b0;
        // Edge memory: only edges seen while unmasked are kept.
        if (irqIn[i] && !prevQ[i] && !maskQ[i] && !levelQ[i])
          pendQ[i] <= 1'b1;
        else if (won || (st.wrLow && hitW && (wdata[16] || wdata[15])))
          pendQ[i] <= 1'b0;
      end
    end
  end

  assign idRd      = idQ;
  assign loRd      = entryOk ? {15'd0, maskQ[entIdx], levelQ[entIdx], remoteQ[entIdx],
                                6'd0, vecQ[entIdx]} : 32'd0;
  assign hiRd      = entryOk ? {destQ[entIdx], 24'd0} : 32'd0;
  assign msgVector = msgVecQ;
  assign msgDest   = msgDestQ;

  // R8: granting a level entry leaves its remote-pending flag set.
  a_r8_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
    (st.fire && levelQ[grantIdx]) |=> remoteQ[$past(grantIdx)]);

  // R5: a low-word write lands in the mask bit of the addressed entry.
  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st.wrLow && entryOk) |=> (maskQ[$past(entIdx)] == $past(wdata[16])));

  // R6: a masked line is never the arbitration winner.
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st.fire |-> !maskQ[grantIdx]);

endmodule

// File: rtl/irt_control.sv
module irt_control
  import irt_pkg::*;
#(
  parameter int         NUM_LINES  = 24,
  parameter logic [7:0] SEL_OFF    = 8'h00,
  parameter logic [7:0] WIN_OFF    = 8'h10,
  parameter logic [7:0] ID_IDX     = 8'h00,
  parameter logic [7:0] VER_IDX    = 8'h01,
  parameter logic [7:0] TABLE_BASE = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        msgReady,
  output logic        msgValid,
  input  logic        reqAny,
  input  logic [7:0]  idRd,
  input  logic [31:0] loRd,
  input  logic [31:0] hiRd,
  output irt_strobe_t st
);

  localparam logic [7:0] LAST_ENTRY = 8'(NUM_LINES - 1);

  logic [7:0] selQ, tblOff;
  logic       outValidQ, selHit, winHit, inTable, upperHalf;

  assign selHit    = (busAddr == SEL_OFF);
  assign winHit    = (busAddr == WIN_OFF);
  assign tblOff    = selQ - TABLE_BASE;
  assign inTable   = (selQ >= TABLE_BASE) && (int'(tblOff) < 2 * NUM_LINES);
  assign upperHalf = tblOff[0];

  always_comb begin
    st        = '0;
    st.entry  = {1'b0, tblOff[7:1]};
    st.wrId   = busWr && winHit && (selQ == ID_IDX);
    st.wrLow  = busWr && winHit && inTable && !upperHalf;
    st.wrHigh = busWr && winHit && inTable && upperHalf;
    st.fire   = reqAny && !outValidQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selQ      <= '0;
      outValidQ <= 1'b0;
    end else begin
      if (busWr && selHit) selQ <= busWdata[7:0];
      if (st.fire)
        outValidQ <= 1'b1;
      else if (msgReady)
        outValidQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (selHit)
        busRdata = {24'd0, selQ};
      else if (winHit) begin
        if (selQ == ID_IDX)
          busRdata = {idRd, 24'd0};
        else if (selQ == VER_IDX)
          busRdata = {8'd0, LAST_ENTRY, 8'd0, VERSION_CODE};
        else if (inTable)
          busRdata = upperHalf ? hiRd : loRd;
      end
    end
  end

  assign msgValid = outValidQ;

  // R10: no new grant while a message is still waiting for acceptance.
  a_r10_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    outValidQ |-> !st.fire);

  // R10: an unaccepted message stays valid.
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (outValidQ && !msgReady) |=> outValidQ);

  // R2: the select register only moves on a write to its own offset.
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWr && selHit) |=> $stable(selQ));

endmodule

// File: rtl/irq_redirect_table.sv
module irq_redirect_table
  import irt_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [7:0]           msgVector,
  output logic [7:0]           msgDest,
  input  logic                 eoiValid,
  input  logic [7:0]           eoiVector
);

  irt_strobe_t st;
  logic        reqAny;
  logic [7:0]  idRd;
  logic [31:0] loRd, hiRd;

  irt_control #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .msgReady (msgReady),
    .msgValid (msgValid),
    .reqAny   (reqAny),
    .idRd     (idRd),
    .loRd     (loRd),
    .hiRd     (hiRd),
    .st       (st)
  );

  irt_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .wdata     (busWdata),
    .irqIn     (irqIn),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .reqAny    (reqAny),
    .idRd      (idRd),
    .loRd      (loRd),
    .hiRd      (hiRd),
    .msgVector (msgVector),
    .msgDest   (msgDest)
  );

  // R10: a presented message does not change until it is accepted.
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (msgValid && !msgReady) |=> ($stable(msgVector) && $stable(msgDest)));

endmodule

// File: tb/test_irq_redirect_table.sv
module test_irq_redirect_table;

  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWr = 1'b0, busRd = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  irqIn = '0;
  logic          msgValid, msgReady = 1'b0;
  logic [7:0]    msgVector, msgDest;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  irq_redirect_table #(.NUM_LINES(N)) i_irq_redirect_table (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .msgValid(msgValid),
    .msgReady(msgReady), .msgVector(msgVector), .msgDest(msgDest),
    .eoiValid(eoiValid), .eoiVector(eoiVector)
  );

  always #2 clk = ~clk;  // 250 MHz

  // {select index, written word, expected readback}
  localparam logic [71:0] VECS [7] = '{
    {8'h00, 32'hABCD_EF12, 32'hAB00_0000},  // R3
    {8'h01, 32'hFFFF_FFFF, 32'h0017_0011},  // R4
    {8'h10, 32'hFFFF_FFFF, 32'h0001_80FF},  // R5 entry 0 low
    {8'h11, 32'hFFFF_FFFF, 32'hFF00_0000},  // R5 entry 0 high
    {8'h3F, 32'h1234_5678, 32'h1200_0000},  // R5 entry 23 high
    {8'h3E, 32'h0001_0033, 32'h0001_0033},  // R5 entry 23 low
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000}   // R5 past the table
  };

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, act %0d cycles exp fewer", cycles);
      finishRun();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act 0x%08h exp 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [31:0] d);
    busWrite(8'h00, {24'd0, idx});
    busWrite(8'h10, d);
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [31:0] d);
    busWrite(8'h00, {24'd0, idx});
    busRead(8'h10, d);
  endtask

  task automatic waitMsg(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (msgValid) seen = 1'b1;
    end
  endtask

  task automatic accept();
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  // Waits for a message, checks it, accepts it.
  task automatic expectMsg(input string req, input logic [7:0] vec, input logic [7:0] dst);
    bit seen;
    waitMsg(seen);
    check({req, " message present"}, {31'd0, seen}, 32'd1);
    if (seen) begin
      check({req, " vector/dest"}, {16'd0, msgVector, msgDest}, {16'd0, vec, dst});
      accept();
    end
  endtask

  task automatic expectQuiet(input string req, input int n);
    bit any = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msgValid) any = 1'b1;
    end
    check({req, " no message"}, {31'd0, any}, 32'd0);
  endtask

  task automatic pulseEoi(input logic [7:0] v);
    eoiVector = v; eoiValid = 1'b1;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    busRead(8'h00, rd);
    check("R1 select after reset", rd, 32'd0);
    check("R1 msgValid after reset", {31'd0, msgValid}, 32'd0);
    regRead(8'h1A, rd);
    check("R1 entry 5 low after reset", rd, 32'h0001_0000);
    regRead(8'h1B, rd);
    check("R1 entry 5 high after reset", rd, 32'h0);

    // R3 R4 R5: register access vectors
    for (int v = 0; v < 7; v++) begin
      regWrite(VECS[v][71:64], VECS[v][63:32]);
      regRead(VECS[v][71:64], rd);
      check($sformatf("R3/R4/R5 vector %0d", v), rd, VECS[v][31:0]);
    end

    // R2: select readback and unused offsets
    busWrite(8'h00, 32'hFFFF_FF12);
    busRead(8'h00, rd);
    check("R2 select readback", rd, 32'h12);
    busWrite(8'h04, 32'h0000_0055);
    busRead(8'h00, rd);
    check("R2 write to unused offset ignored", rd, 32'h12);
    busRead(8'h04, rd);
    check("R2 unused offset reads zero", rd, 32'h0);

    // R7: edge entry 4, vector 0x31, dest 0x22
    regWrite(8'h19, 32'h2200_0000);
    regWrite(8'h18, 32'h0000_0031);
    @(negedge clk); irqIn[4] = 1'b1;
    expectMsg("R7 first edge", 8'h31, 8'h22);
    expectQuiet("R7 held input", 10);
    @(negedge clk); irqIn[4] = 1'b0;
    @(negedge clk); irqIn[4] = 1'b1;
    expectMsg("R7 second edge", 8'h31, 8'h22);
    irqIn[4] = 1'b0;

    // R6: masked edge and masked level entries
    regWrite(8'h1A, 32'h0001_0035);
    @(negedge clk); irqIn[5] = 1'b1;
    expectQuiet("R6 masked edge", 10);
    regWrite(8'h1A, 32'h0000_0035);
    expectQuiet("R6 edge not remembered", 10);
    irqIn[5] = 1'b0;
    regWrite(8'h1C, 32'h0001_8036);
    @(negedge clk); irqIn[6] = 1'b1;
    expectQuiet("R6 masked level", 10);
    irqIn[6] = 1'b0;

    // R10: priority and hold
    regWrite(8'h21, 32'h0800_0000);
    regWrite(8'h20, 32'h0000_0048);
    regWrite(8'h23, 32'h0900_0000);
    regWrite(8'h22, 32'h0000_0049);
    @(negedge clk); irqIn[9:8] = 2'b11;
    begin
      bit seen;
      waitMsg(seen);
      check("R10 first message present", {31'd0, seen}, 32'd1);
      check("R10 lowest line first", {24'd0, msgVector}, 32'h48);
      repeat (3) @(negedge clk);
      check("R10 held while not ready", {23'd0, msgValid, msgVector}, {23'd0, 1'b1, 8'h48});
      accept();
      check("R10 valid low after accept", {31'd0, msgValid}, 32'd0);
    end
    expectMsg("R10 second line", 8'h49, 8'h09);
    irqIn[9:8] = 2'b00;

    // R8 R9: level entry 10, vector 0x50, dest 0x05
    regWrite(8'h25, 32'h0500_0000);
    regWrite(8'h24, 32'h0000_8050);
    @(negedge clk); irqIn[10] = 1'b1;
    expectMsg("R8 level first", 8'h50, 8'h05);
    regRead(8'h24, rd);
    check("R8 remote flag set", rd, 32'h0000_C050);
    expectQuiet("R8 no repeat before EOI", 10);
    pulseEoi(8'h51);
    expectQuiet("R9 wrong vector EOI", 10);
    regRead(8'h24, rd);
    check("R9 remote flag kept", rd, 32'h0000_C050);
    pulseEoi(8'h50);
    expectMsg("R8 reissue after EOI", 8'h50, 8'h05);
    @(negedge clk); irqIn[10] = 1'b0;
    pulseEoi(8'h50);
    expectQuiet("R8 input low after EOI", 10);
    regRead(8'h24, rd);
    check("R8 remote flag cleared", rd, 32'h0000_8050);

    // R11: EOI for line 12 in the cycle line 13 is granted (same vector)
    regWrite(8'h29, 32'h0C00_0000);
    regWrite(8'h28, 32'h0000_8060);
    regWrite(8'h2B, 32'h0D00_0000);
    regWrite(8'h2A, 32'h0000_8060);
    @(negedge clk); irqIn[13:12] = 2'b11;
    begin
      bit seen;
      waitMsg(seen);
      check("R11 first message present", {31'd0, seen}, 32'd1);
      check("R11 line 12 first", {24'd0, msgDest}, 32'h0C);
      accept();
      pulseEoi(8'h60);
    end
    expectMsg("R11 line 13 granted", 8'h60, 8'h0D);
    regRead(8'h2A, rd);
    check("R11 granted flag set wins", rd, 32'h0000_C060);
    expectMsg("R11 released line again", 8'h60, 8'h0C);
    irqIn[13:12] = 2'b00;

    done = 1'b1;
    finishRun();
  end

endmodule